// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block issues data addresses from a small bank of pointer registers and updates the used pointer after each access. Every access names a pointer and, independently, one of the step registers. The pointer's present value goes out as the address in that cycle, and on the next clock edge the pointer moves by the signed step.

Each pointer has a length register. When the length is zero, the pointer moves with plain modulo-2^14 arithmetic. When the length is non-zero, the pointer stays inside a circular buffer of that many words. The buffer starts at an aligned base: the pointer with its low bits cleared, where the number of cleared bits is that of the smallest power of two that is at least the length.

A single write port loads any pointer, step or length register. A combinational read port returns the stored value of any register. The intended user is a sequencer that issues one indirect access per cycle and sets up buffers through the write port.

Top module: `circ_agen`

## Requirements
- R1: After a synchronous active-low reset, every pointer, step and length register reads back as zero.
- R2: When `wr_en` is high, `wr_data` is stored at the next rising edge into register `wr_sel` of the bank chosen by `wr_kind`: 0 selects pointers, 1 selects steps, 2 selects lengths. Code 3 stores nothing. The read port uses the same kind codes and returns zero for code 3.
- R3: `addr_o` always equals the present value of pointer `acc_isel`. The update takes effect only after the edge (post-modify).
- R4: An access to a pointer whose length is zero sets that pointer to (pointer + step) mod 2^14. The step is a 14-bit two's-complement value.
- R5: An access to a pointer with non-zero length L that lies inside its buffer, using a step of magnitude at most L, leaves the pointer inside the buffer from base to base+L-1. Stepping past the top end moves it back by L.
- R6: A negative step that would go below the base wraps the pointer to the top of the buffer by adding L.
- R7: The step register is chosen by `acc_msel` independently of the pointer chosen by `acc_isel`. The length used is always the one that belongs to the pointer.
- R8: When a pointer write and an access to the same pointer occur in the same cycle, the written value is kept and the update is dropped.
- R9: An access changes only the selected pointer. Step and length registers change only through the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Perform an indirect access with post-modify |
| acc_isel | input | 2 | Pointer used for the access |
| acc_msel | input | 2 | Step register used for the update |
| addr_o | output | 14 | Address issued (pointer value before the update) |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Bank written: 0 pointer, 1 step, 2 length, 3 none |
| wr_sel | input | 2 | Register index within the bank |
| wr_data | input | 14 | Value to write |
| rd_kind | input | 2 | Bank read: 0 pointer, 1 step, 2 length, 3 reads zero |
| rd_sel | input | 2 | Register index read |
| rd_data | output | 14 | Value of the register read |

## Verification
The update path is tried with four kinds of input:
- Linear stepping with zero length, including a pass over the top of the 14-bit space, tells modulo-2^14 wrap apart from buffer wrap.
- A positive step past the top of a 10-word buffer and a negative step below the base of a 5-word buffer tell the subtract-L and add-L corrections apart. They also check that the base is aligned to 16 and 8 words respectively.
- Pairing one pointer with another pointer's step register, and writing a pointer while it is being accessed, separate the step selection from the pointer selection and settle the write-over-update priority.
- A long random run with mixed lengths, pointer writes and register reads compares every cycle against a behavioural model.

// File: rtl/agen_pkg.sv
// Shared encodings for the circular buffer address generator.
// Assumes: the kind code is used by both the write port and the read port.
package agen_pkg;
    typedef enum logic [1:0] {
        KIND_IDX  = 2'd0,
        KIND_MOD  = 2'd1,
        KIND_LEN  = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/agen_regs.sv
// Register banks: pointers, steps and lengths.
// Assumes: an explicit pointer write wins over a post-modify of the same pointer.
// Step and length registers change only through the write port.
module agen_regs #(
    parameter int AW   = 14,
    parameter int NPTR = 4,
    localparam int SELW = $clog2(NPTR)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_kind,
    input  logic [SELW-1:0]           wr_sel,
    input  logic [AW-1:0]             wr_data,
    input  logic                      upd_en,
    input  logic [SELW-1:0]           upd_sel,
    input  logic [AW-1:0]             upd_val,
    output logic [NPTR-1:0][AW-1:0]   i_q,
    output logic [NPTR-1:0][AW-1:0]   m_q,
    output logic [NPTR-1:0][AW-1:0]   l_q
);
    import agen_pkg::*;

    for (genvar g = 0; g < NPTR; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_sel == SELW'(g));

        // Pointer: the write has priority, otherwise take the post-modify result.
        always_ff @(posedge clk) begin
            if (!rst_n)
                i_q[g] <= '0;
            else if (hit && wr_kind == KIND_IDX)
                i_q[g] <= wr_data;
            else if (upd_en && upd_sel == SELW'(g))
                i_q[g] <= upd_val;
        end

        // Step register: loaded only by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                m_q[g] <= '0;
            else if (hit && wr_kind == KIND_MOD)
                m_q[g] <= wr_data;
        end

        // Length register: loaded only by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                l_q[g] <= '0;
            else if (hit && wr_kind == KIND_LEN)
                l_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/agen_wrap.sv
// Next-pointer calculation with optional modulo wrap.
// Assumes: with a non-zero length, |step| <= length and the pointer lies inside its buffer.
// The base is the pointer with the low bits cleared, up to the next power of two >= length.
module agen_wrap #(
    parameter int AW = 14
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0]        mask;
    logic [AW-1:0]        base;
    logic signed [AW+1:0] offs;
    logic signed [AW+1:0] sstep;
    logic signed [AW+1:0] slen;
    logic signed [AW+1:0] n;
    logic signed [AW+1:0] nfix;

    // Build the alignment mask by smearing (len-1) toward bit 0.
    always_comb begin
        mask = len - AW'(1);
        for (int k = 0; k < AW; k++)
            mask = mask | (mask >> 1);
    end

    // Offset inside the buffer plus the signed step, corrected by one length.
    always_comb begin
        base  = ptr & ~mask;
        offs  = $signed({2'b00, ptr & mask});
        sstep = $signed({{2{step[AW-1]}}, step});
        slen  = $signed({2'b00, len});
        n     = offs + sstep;
        if (n >= slen)
            nfix = n - slen;
        else if (n < 0)
            nfix = n + slen;
        else
            nfix = n;
    end

    // Select linear or circular result.
    always_comb begin
        if (len == '0)
            nxt = ptr + step;
        else
            nxt = base + nfix[AW-1:0];
    end
endmodule

// File: rtl/circ_agen.sv
// Circular buffer address generator top.
// Issues the selected pointer as the address and post-modifies it by a chosen step register.
// Assumes: one access per cycle; the read port is combinational.
module circ_agen #(
    parameter int AW   = 14,
    parameter int NPTR = 4,
    localparam int SELW = $clog2(NPTR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_en,
    input  logic [SELW-1:0] acc_isel,
    input  logic [SELW-1:0] acc_msel,
    output logic [AW-1:0]   addr_o,
    input  logic            wr_en,
    input  logic [1:0]      wr_kind,
    input  logic [SELW-1:0] wr_sel,
    input  logic [AW-1:0]   wr_data,
    input  logic [1:0]      rd_kind,
    input  logic [SELW-1:0] rd_sel,
    output logic [AW-1:0]   rd_data
);
    import agen_pkg::*;

    logic [NPTR-1:0][AW-1:0] i_q;
    logic [NPTR-1:0][AW-1:0] m_q;
    logic [NPTR-1:0][AW-1:0] l_q;
    logic [AW-1:0]           upd_val;

    agen_regs #(.AW(AW), .NPTR(NPTR)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .upd_en  (acc_en),
        .upd_sel (acc_isel),
        .upd_val (upd_val),
        .i_q     (i_q),
        .m_q     (m_q),
        .l_q     (l_q)
    );

    agen_wrap #(.AW(AW)) u_wrap (
        .ptr  (i_q[acc_isel]),
        .step (m_q[acc_msel]),
        .len  (l_q[acc_isel]),
        .nxt  (upd_val)
    );

    // Post-modify addressing: the address is the pointer before the update.
    assign addr_o = i_q[acc_isel];

    // Read port mux over the three banks.
    always_comb begin
        unique case (wr_kind_cast(rd_kind))
            KIND_IDX: rd_data = i_q[rd_sel];
            KIND_MOD: rd_data = m_q[rd_sel];
            KIND_LEN: rd_data = l_q[rd_sel];
            default:  rd_data = '0;
        endcase
    end

    function automatic reg_kind_e wr_kind_cast(input logic [1:0] v);
        return reg_kind_e'(v);
    endfunction
endmodule

// File: rtl/agen_chk.sv
// Assertion checker bound to circ_agen; it observes the ports and the register banks.
module agen_chk #(
    parameter int AW   = 14,
    parameter int NPTR = 4,
    localparam int SELW = $clog2(NPTR)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_en,
    input logic [SELW-1:0]         acc_isel,
    input logic [SELW-1:0]         acc_msel,
    input logic                    wr_en,
    input logic [1:0]              wr_kind,
    input logic [SELW-1:0]         wr_sel,
    input logic [AW-1:0]           wr_data,
    input logic [NPTR-1:0][AW-1:0] i_q,
    input logic [NPTR-1:0][AW-1:0] m_q,
    input logic [NPTR-1:0][AW-1:0] l_q
);
    logic [AW-1:0] cur_i, cur_m, cur_l, lin_next, bmask;
    logic          collide, in_buf, small_step;
    logic [AW-1:0] step_mag;

    // Helper view of the access operands.
    always_comb begin
        cur_i    = i_q[acc_isel];
        cur_m    = m_q[acc_msel];
        cur_l    = l_q[acc_isel];
        lin_next = cur_i + cur_m;
        collide  = wr_en && wr_kind == 2'd0 && wr_sel == acc_isel;
        bmask    = cur_l - AW'(1);
        for (int k = 0; k < AW; k++)
            bmask = bmask | (bmask >> 1);
        in_buf     = (cur_i & bmask) < cur_l;
        step_mag   = cur_m[AW-1] ? (~cur_m + AW'(1)) : cur_m;
        small_step = step_mag <= cur_l;
    end

    // R2
    idx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == 2'd0) |=> i_q[$past(wr_sel)] == $past(wr_data));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !collide && cur_l == '0) |=> i_q[$past(acc_isel)] == $past(lin_next));

    // R5
    wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !collide && cur_l != '0 && in_buf && small_step) |=>
        (((i_q[$past(acc_isel)] & $past(bmask)) < $past(cur_l)) &&
         ((i_q[$past(acc_isel)] & ~$past(bmask)) == ($past(cur_i) & ~$past(bmask)))));

    // R9
    mod_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(m_q) && $stable(l_q)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !acc_en) |=> $stable(i_q));
endmodule

bind circ_agen agen_chk #(.AW(AW), .NPTR(NPTR)) u_chk (.*);

// File: tb/tb_circ_agen.sv
module tb_circ_agen;
    localparam int AW = 14;
    localparam int MSK = (1 << AW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0;
    logic [1:0] acc_isel = '0, acc_msel = '0;
    logic [AW-1:0] addr_o;
    logic       wr_en = 1'b0;
    logic [1:0] wr_kind = '0, wr_sel = '0;
    logic [AW-1:0] wr_data = '0;
    logic [1:0] rd_kind = '0, rd_sel = '0;
    logic [AW-1:0] rd_data;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    int mi[4], mm[4], ml[4];
    bit done = 0;

    always #10 clk = ~clk;

    circ_agen dut (.*);

    function automatic int ref_next(int i, int m, int l);
        int sm = (m >= (1 << (AW - 1))) ? m - (1 << AW) : m;
        int p = 1, base, n;
        if (l == 0) return (i + sm) & MSK;
        while (p < l) p = p * 2;
        base = i - (i % p);
        n = (i - base) + sm;
        if (n >= l) n = n - l;
        else if (n < 0) n = n + l;
        return (base + n) & MSK;
    endfunction

    function automatic int ref_read(int k, int s);
        case (k)
            0: return mi[s];
            1: return mm[s];
            2: return ml[s];
            default: return 0;
        endcase
    endfunction

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare, then advance the model at posedge.
    task automatic step(bit a, int is, int ms, bit w, int wk, int ws, int wd, int rk, int rs);
        int nx;
        acc_en = a; acc_isel = 2'(is); acc_msel = 2'(ms);
        wr_en = w; wr_kind = 2'(wk); wr_sel = 2'(ws); wr_data = AW'(wd);
        rd_kind = 2'(rk); rd_sel = 2'(rs);
        #1;
        cmp("addr_o", int'(addr_o), mi[is]);
        cmp("rd_data", int'(rd_data), ref_read(rk, rs));
        @(posedge clk);
        nx = ref_next(mi[is], mm[ms], ml[is]);
        if (a) mi[is] = nx;
        if (w) begin
            if (wk == 0) mi[ws] = wd & MSK;
            if (wk == 1) mm[ws] = wd & MSK;
            if (wk == 2) ml[ws] = wd & MSK;
        end
        @(negedge clk);
    endtask

    task automatic wr(int k, int s, int d);
        step(0, 0, 0, 1, k, s, d, k, s);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        foreach (mi[k]) begin mi[k] = 0; mm[k] = 0; ml[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: all registers zero after reset
        cur_req = "R1";
        for (int k = 0; k < 3; k++)
            for (int s = 0; s < 4; s++) step(0, 0, 0, 0, 0, 0, 0, k, s);
        // R2: writes of each kind, code 3 ignored
        cur_req = "R2";
        wr(0, 0, 100); wr(1, 0, 1); wr(0, 1, 16383); wr(1, 1, 2);
        wr(3, 2, 777); step(0, 0, 0, 0, 0, 0, 0, 3, 2);
        for (int s = 0; s < 4; s++) step(0, 0, 0, 0, 0, 0, 0, 0, s);
        // R3/R4: post-modify linear, including 14-bit wrap
        cur_req = "R3";
        repeat (3) step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        cur_req = "R4";
        step(1, 1, 1, 0, 0, 0, 0, 0, 1);
        step(0, 1, 1, 0, 0, 0, 0, 0, 1);
        // R5: length 10, base 256, step 3 wraps past the top
        cur_req = "R5";
        wr(2, 2, 10); wr(1, 2, 3); wr(0, 2, 263);
        repeat (5) step(1, 2, 2, 0, 0, 0, 0, 0, 2);
        // R6: length 5, base 512, step -4 wraps below the base
        cur_req = "R6";
        wr(2, 3, 5); wr(1, 3, 16380); wr(0, 3, 513);
        repeat (4) step(1, 3, 3, 0, 0, 0, 0, 0, 3);
        // R7: pointer 2 stepped with step register 3
        cur_req = "R7";
        repeat (4) step(1, 2, 3, 0, 0, 0, 0, 0, 2);
        // R8: write and access of the same pointer in one cycle
        cur_req = "R8";
        step(1, 2, 2, 1, 0, 2, 258, 0, 2);
        step(0, 2, 2, 0, 0, 0, 0, 0, 2);
        // R9: steps and lengths untouched by accesses
        cur_req = "R9";
        for (int s = 0; s < 4; s++) begin
            step(1, s, s, 0, 0, 0, 0, 1, s);
            step(1, s, 0, 0, 0, 0, 0, 2, s);
        end
        // Random run: |step| <= every non-zero length
        cur_req = "R5";
        wr(2, 0, 0); wr(2, 1, 7); wr(2, 2, 12); wr(2, 3, 16);
        wr(1, 0, 1); wr(1, 1, 16381); wr(1, 2, 5); wr(1, 3, 16377);
        for (int t = 0; t < 600; t++) begin
            int r = $urandom_range(0, 9);
            step(r != 0, $urandom_range(0, 3), $urandom_range(0, 3),
                 r < 2, 0, $urandom_range(0, 3), $urandom_range(0, MSK),
                 $urandom_range(0, 3), $urandom_range(0, 3));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule